// File: doc/BRIEF.md
# Dual-Axis Byte Bus Register Interface

This block sits between a host processor's 8-bit parallel bus and the datapaths of two counter axes, X and Y. The host uses an active-low chip-select, active-low read and write strobes, a control/data select line and an axis select line. Each axis has a 24-bit preset value. The host writes it one byte at a time, and a per-axis byte pointer steps through the bytes. The host reads each axis's 24-bit latched count the same way. It also reads a flag byte per axis.

Control bytes written by the host are decoded into one-cycle command pulses for the counter datapaths, or into per-axis mode registers. Bits 6:5 of the control byte choose the target. When bit 7 is set, the write goes to both axes. The strobes are synchronized to the system clock and edge-detected. Read data comes out on a separate output with its own output-enable, and the chip's pad ring supplies the tri-state driver.

Top module: `dual_axis_busregs`

## Requirements
- R1: After reset, both presets, all mode registers and both byte pointers are zero, no command pulse is active, and `bus_oe` is low.
- R2: A data write (`bus_cd`=0) stores `bus_din` into the preset byte chosen by the selected axis's pointer (`bus_sel_y`=0 selects X, 1 selects Y). Pointer values 0, 1 and 2 select bits 7:0, 15:8 and 23:16. The other axis's preset is unchanged.
- R3: Each data write or data read advances only the selected axis's byte pointer, in the order 0, 1, 2, 0.
- R4: On a control write (`bus_cd`=1), `bus_din[6:5]` picks the target. 00 is a command. 01 loads the count-mode register from `bus_din[4:0]`. 10 loads the I/O register from `bus_din[4:0]`. 11 loads the index register from `bus_din[2:0]`. Registers that are not targeted keep their values.
- R5: A control write with `bus_din[7]`=1 acts on both axes, whatever `bus_sel_y` is. With `bus_din[7]`=0 it acts on the axis chosen by `bus_sel_y` only.
- R6: A command with bit 0 set returns the target axis's byte pointer to 0 and emits no pulse.
- R7: Command bits 2:1 give a pulse of one clock cycle: 01 on `cnt_reset_o`, 10 on `stat_clear_o`, 11 on `err_clear_o`. Bit 0 of each pulse vector is X and bit 1 is Y.
- R8: Command bits 4:3 give a pulse of one clock cycle: 01 on `cnt_load_o`, 10 on `latch_load_o`, 11 on `psc_load_o`. The same X/Y bit order applies.
- R9: `bus_oe` is high only while `bus_cs_n` and `bus_rd_n` are both low, and `bus_dout` is 0 otherwise. A data read returns the byte of the selected axis's latch that its pointer selects. A control read returns {0, flags[6:0]} of the selected axis and does not move the pointer.
- R10: A write takes effect only on the rising edge of `bus_wr_n` while `bus_cs_n` is low. A strobe with `bus_cs_n` high changes nothing.
- R11: Each strobe acts exactly once, however long it is held low. Its register updates, pointer step and pulses appear at the third rising clock edge after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| bus_cd | input | 1 | 0 selects data, 1 selects control/flags |
| bus_sel_y | input | 1 | 0 selects axis X, 1 selects axis Y |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_oe | output | 1 | Read data enable for the pad driver |
| x_latch_i | input | 24 | X latched count value |
| y_latch_i | input | 24 | Y latched count value |
| x_flags_i | input | 7 | X status flags |
| y_flags_i | input | 7 | Y status flags |
| x_preset_o | output | 24 | X preset value |
| y_preset_o | output | 24 | Y preset value |
| x_cnt_mode_o | output | 5 | X count-mode register |
| y_cnt_mode_o | output | 5 | Y count-mode register |
| x_io_mode_o | output | 5 | X I/O register |
| y_io_mode_o | output | 5 | Y I/O register |
| x_idx_mode_o | output | 3 | X index register |
| y_idx_mode_o | output | 3 | Y index register |
| cnt_reset_o | output | 2 | Counter reset pulse per axis |
| stat_clear_o | output | 2 | Status-toggle and sign clear pulse per axis |
| err_clear_o | output | 2 | Error flag clear pulse per axis |
| cnt_load_o | output | 2 | Preset-to-counter load pulse per axis |
| latch_load_o | output | 2 | Counter-to-latch transfer pulse per axis |
| psc_load_o | output | 2 | Preset low byte to prescaler pulse per axis |

## Verification
Read data depends only on the current bus lines and pointers, so the bench samples `bus_dout` two falling edges after asserting the read, while the strobe is still low. Preset, mode and pointer effects appear at the third rising edge after a strobe is released. The bench waits at least four cycles after each release before it checks. One long write checks the timing exactly: the value must still be old at the second falling edge after release and new at the third. Command pulses last one cycle and can come from either axis. The driver therefore queues the expected 12-bit pulse pattern before each control write, and a monitor compares every nonzero pattern it sees against the head of the queue. Any entry left in the queue at the end is a missed pulse.

// File: rtl/dab_pkg.sv
package dab_pkg;

    localparam int DAB_DW = 8;

    typedef enum logic [1:0] {
        TGT_CMD = 2'b00,
        TGT_CNT = 2'b01,
        TGT_IO  = 2'b10,
        TGT_IDX = 2'b11
    } ctl_tgt_e;

    typedef struct packed {
        logic psc_load;
        logic latch_load;
        logic cnt_load;
        logic err_clr;
        logic stat_clr;
        logic cnt_rst;
    } cmd_pulse_t;

    typedef struct packed {
        logic              cs_n;
        logic              rd_n;
        logic              wr_n;
        logic              cd;
        logic              sel_y;
        logic [DAB_DW-1:0] din;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                      cd: 1'b0, sel_y: 1'b0, din: '0};

endpackage

// File: rtl/dab_strobe_sync.sv
module dab_strobe_sync
    import dab_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_smp_t          bus_i,
    output logic              wr_evt_o,
    output logic              rd_evt_o,
    output logic              cd_o,
    output logic              sel_y_o,
    output logic [DAB_DW-1:0] din_o
);

    // One extra stage holds the last sample taken while a strobe was low.
    localparam int DEPTH = STAGES + 1;

    bus_smp_t pipe_d [DEPTH];
    bus_smp_t pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = bus_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= BUS_IDLE;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    // Rising strobe: newer stage high, held stage low with chip-select low.
    assign wr_evt_o = pipe_q[DEPTH-2].wr_n && !pipe_q[DEPTH-1].wr_n
                      && !pipe_q[DEPTH-1].cs_n;
    assign rd_evt_o = pipe_q[DEPTH-2].rd_n && !pipe_q[DEPTH-1].rd_n
                      && !pipe_q[DEPTH-1].cs_n;
    assign cd_o     = pipe_q[DEPTH-1].cd;
    assign sel_y_o  = pipe_q[DEPTH-1].sel_y;
    assign din_o    = pipe_q[DEPTH-1].din;

endmodule

// File: rtl/dab_axis_regs.sv
module dab_axis_regs
    import dab_pkg::*;
#(
    parameter int BYTES      = 3,
    parameter int CNT_MODE_W = 5,
    parameter int IO_MODE_W  = 5,
    parameter int IDX_MODE_W = 3,
    localparam int PTR_W     = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int PW        = BYTES * DAB_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_wr_i,
    input  logic                  ctrl_wr_i,
    input  logic                  data_rd_i,
    input  logic [DAB_DW-1:0]     din_i,
    output logic [PW-1:0]         preset_o,
    output logic [PTR_W-1:0]      ptr_o,
    output logic [CNT_MODE_W-1:0] cnt_mode_o,
    output logic [IO_MODE_W-1:0]  io_mode_o,
    output logic [IDX_MODE_W-1:0] idx_mode_o,
    output cmd_pulse_t            cmd_o
);

    typedef struct packed {
        logic [PW-1:0]         preset;
        logic [PTR_W-1:0]      ptr;
        logic [CNT_MODE_W-1:0] cnt_mode;
        logic [IO_MODE_W-1:0]  io_mode;
        logic [IDX_MODE_W-1:0] idx_mode;
        cmd_pulse_t            cmd;
    } axis_st_t;

    axis_st_t st_d;
    axis_st_t st_q;
    ctl_tgt_e tgt;

    assign tgt = ctl_tgt_e'(din_i[6:5]);

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;

        if (data_wr_i) begin
            for (int b = 0; b < BYTES; b++) begin
                if (st_q.ptr == PTR_W'(b)) begin
                    st_d.preset[b*DAB_DW +: DAB_DW] = din_i;
                end
            end
        end

        if (data_wr_i || data_rd_i) begin
            st_d.ptr = (st_q.ptr == PTR_W'(BYTES - 1)) ? '0 : st_q.ptr + 1'b1;
        end

        if (ctrl_wr_i) begin
            unique case (tgt)
                TGT_CMD: begin
                    if (din_i[0]) begin
                        st_d.ptr = '0;
                    end
                    unique case (din_i[2:1])
                        2'b01:   st_d.cmd.cnt_rst  = 1'b1;
                        2'b10:   st_d.cmd.stat_clr = 1'b1;
                        2'b11:   st_d.cmd.err_clr  = 1'b1;
                        default: ;
                    endcase
                    unique case (din_i[4:3])
                        2'b01:   st_d.cmd.cnt_load   = 1'b1;
                        2'b10:   st_d.cmd.latch_load = 1'b1;
                        2'b11:   st_d.cmd.psc_load   = 1'b1;
                        default: ;
                    endcase
                end
                TGT_CNT: st_d.cnt_mode = din_i[CNT_MODE_W-1:0];
                TGT_IO:  st_d.io_mode  = din_i[IO_MODE_W-1:0];
                TGT_IDX: st_d.idx_mode = din_i[IDX_MODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign preset_o   = st_q.preset;
    assign ptr_o      = st_q.ptr;
    assign cnt_mode_o = st_q.cnt_mode;
    assign io_mode_o  = st_q.io_mode;
    assign idx_mode_o = st_q.idx_mode;
    assign cmd_o      = st_q.cmd;

endmodule

// File: rtl/dab_read_mux.sv
module dab_read_mux
    import dab_pkg::*;
#(
    parameter int BYTES  = 3,
    parameter int FLAG_W = 7,
    localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int PW    = BYTES * DAB_DW
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              cd,
    input  logic              sel_y,
    input  logic [PW-1:0]     x_latch_i,
    input  logic [PW-1:0]     y_latch_i,
    input  logic [FLAG_W-1:0] x_flags_i,
    input  logic [FLAG_W-1:0] y_flags_i,
    input  logic [PTR_W-1:0]  x_ptr_i,
    input  logic [PTR_W-1:0]  y_ptr_i,
    output logic [DAB_DW-1:0] dout_o,
    output logic              oe_o
);

    logic [PW-1:0]     latch_sel;
    logic [PTR_W-1:0]  ptr_sel;
    logic [FLAG_W-1:0] flag_sel;
    logic [DAB_DW-1:0] byte_sel;

    always_comb begin
        oe_o      = !cs_n && !rd_n;
        latch_sel = sel_y ? y_latch_i : x_latch_i;
        ptr_sel   = sel_y ? y_ptr_i   : x_ptr_i;
        flag_sel  = sel_y ? y_flags_i : x_flags_i;
        byte_sel  = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (ptr_sel == PTR_W'(b)) begin
                byte_sel = latch_sel[b*DAB_DW +: DAB_DW];
            end
        end
        dout_o = '0;
        if (oe_o) begin
            dout_o = cd ? DAB_DW'(flag_sel) : byte_sel;
        end
    end

endmodule

// File: rtl/dual_axis_busregs.sv
module dual_axis_busregs
    import dab_pkg::*;
#(
    parameter int BYTES       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FLAG_W      = 7,
    parameter int CNT_MODE_W  = 5,
    parameter int IO_MODE_W   = 5,
    parameter int IDX_MODE_W  = 3,
    localparam int PW         = BYTES * DAB_DW,
    localparam int PTR_W      = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_cs_n,
    input  logic                  bus_rd_n,
    input  logic                  bus_wr_n,
    input  logic                  bus_cd,
    input  logic                  bus_sel_y,
    input  logic [DAB_DW-1:0]     bus_din,
    output logic [DAB_DW-1:0]     bus_dout,
    output logic                  bus_oe,
    input  logic [PW-1:0]         x_latch_i,
    input  logic [PW-1:0]         y_latch_i,
    input  logic [FLAG_W-1:0]     x_flags_i,
    input  logic [FLAG_W-1:0]     y_flags_i,
    output logic [PW-1:0]         x_preset_o,
    output logic [PW-1:0]         y_preset_o,
    output logic [CNT_MODE_W-1:0] x_cnt_mode_o,
    output logic [CNT_MODE_W-1:0] y_cnt_mode_o,
    output logic [IO_MODE_W-1:0]  x_io_mode_o,
    output logic [IO_MODE_W-1:0]  y_io_mode_o,
    output logic [IDX_MODE_W-1:0] x_idx_mode_o,
    output logic [IDX_MODE_W-1:0] y_idx_mode_o,
    output logic [1:0]            cnt_reset_o,
    output logic [1:0]            stat_clear_o,
    output logic [1:0]            err_clear_o,
    output logic [1:0]            cnt_load_o,
    output logic [1:0]            latch_load_o,
    output logic [1:0]            psc_load_o
);

    localparam int AXES = 2;

    bus_smp_t          bus_raw;
    logic              wr_evt;
    logic              rd_evt;
    logic              smp_cd;
    logic              smp_sel_y;
    logic [DAB_DW-1:0] smp_din;

    logic [AXES-1:0]       sel_match;
    logic [AXES-1:0]       data_wr;
    logic [AXES-1:0]       ctrl_wr;
    logic [AXES-1:0]       data_rd;
    logic [PW-1:0]         preset_w [AXES];
    logic [PTR_W-1:0]      ptr_w    [AXES];
    logic [CNT_MODE_W-1:0] cnt_w    [AXES];
    logic [IO_MODE_W-1:0]  io_w     [AXES];
    logic [IDX_MODE_W-1:0] idx_w    [AXES];
    cmd_pulse_t            cmd_w    [AXES];
    logic [6*AXES-1:0]     pulse_all;

    assign bus_raw = '{cs_n: bus_cs_n, rd_n: bus_rd_n, wr_n: bus_wr_n,
                       cd: bus_cd, sel_y: bus_sel_y, din: bus_din};

    dab_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_i    (bus_raw),
        .wr_evt_o (wr_evt),
        .rd_evt_o (rd_evt),
        .cd_o     (smp_cd),
        .sel_y_o  (smp_sel_y),
        .din_o    (smp_din)
    );

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        assign sel_match[a] = (smp_sel_y == 1'(a));
        assign data_wr[a]   = wr_evt && !smp_cd && sel_match[a];
        // Bit 7 of a control byte broadcasts to every axis.
        assign ctrl_wr[a]   = wr_evt && smp_cd && (sel_match[a] || smp_din[7]);
        assign data_rd[a]   = rd_evt && !smp_cd && sel_match[a];

        dab_axis_regs #(
            .BYTES      (BYTES),
            .CNT_MODE_W (CNT_MODE_W),
            .IO_MODE_W  (IO_MODE_W),
            .IDX_MODE_W (IDX_MODE_W)
        ) u_axis (
            .clk        (clk),
            .rst_n      (rst_n),
            .data_wr_i  (data_wr[a]),
            .ctrl_wr_i  (ctrl_wr[a]),
            .data_rd_i  (data_rd[a]),
            .din_i      (smp_din),
            .preset_o   (preset_w[a]),
            .ptr_o      (ptr_w[a]),
            .cnt_mode_o (cnt_w[a]),
            .io_mode_o  (io_w[a]),
            .idx_mode_o (idx_w[a]),
            .cmd_o      (cmd_w[a])
        );
    end

    dab_read_mux #(.BYTES(BYTES), .FLAG_W(FLAG_W)) u_rmux (
        .cs_n      (bus_cs_n),
        .rd_n      (bus_rd_n),
        .cd        (bus_cd),
        .sel_y     (bus_sel_y),
        .x_latch_i (x_latch_i),
        .y_latch_i (y_latch_i),
        .x_flags_i (x_flags_i),
        .y_flags_i (y_flags_i),
        .x_ptr_i   (ptr_w[0]),
        .y_ptr_i   (ptr_w[1]),
        .dout_o    (bus_dout),
        .oe_o      (bus_oe)
    );

    assign x_preset_o   = preset_w[0];
    assign y_preset_o   = preset_w[1];
    assign x_cnt_mode_o = cnt_w[0];
    assign y_cnt_mode_o = cnt_w[1];
    assign x_io_mode_o  = io_w[0];
    assign y_io_mode_o  = io_w[1];
    assign x_idx_mode_o = idx_w[0];
    assign y_idx_mode_o = idx_w[1];

    assign cnt_reset_o  = {cmd_w[1].cnt_rst,    cmd_w[0].cnt_rst};
    assign stat_clear_o = {cmd_w[1].stat_clr,   cmd_w[0].stat_clr};
    assign err_clear_o  = {cmd_w[1].err_clr,    cmd_w[0].err_clr};
    assign cnt_load_o   = {cmd_w[1].cnt_load,   cmd_w[0].cnt_load};
    assign latch_load_o = {cmd_w[1].latch_load, cmd_w[0].latch_load};
    assign psc_load_o   = {cmd_w[1].psc_load,   cmd_w[0].psc_load};

    assign pulse_all = {psc_load_o, latch_load_o, cnt_load_o,
                        err_clear_o, stat_clear_o, cnt_reset_o};

endmodule

// File: rtl/dab_checker.sv
module dab_checker #(
    parameter int BYTES  = 3,
    localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_cd,
    input logic             bus_oe,
    input logic [7:0]       bus_dout,
    input logic             wr_evt,
    input logic [11:0]      pulse_all,
    input logic [PTR_W-1:0] x_ptr,
    input logic [PTR_W-1:0] y_ptr,
    input logic [4:0]       x_cnt_mode,
    input logic [2:0]       y_idx_mode
);

    AST_X_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        x_ptr <= PTR_W'(BYTES - 1)); // R3

    AST_Y_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        y_ptr <= PTR_W'(BYTES - 1)); // R3

    AST_X_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_ptr != $past(x_ptr)) |-> (x_ptr == '0 || x_ptr == $past(x_ptr) + 1'b1)); // R3

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n || bus_rd_n) |-> (!bus_oe && bus_dout == 8'h00)); // R9

    AST_FLAG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && bus_cd) |-> !bus_dout[7]); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_all) |=> !(|pulse_all)); // R11

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_all) |-> $past(wr_evt)); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_evt) |-> ($stable(x_cnt_mode) && $stable(y_idx_mode))); // R4

endmodule

bind dual_axis_busregs dab_checker #(.BYTES(BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_cd     (bus_cd),
    .bus_oe     (bus_oe),
    .bus_dout   (bus_dout),
    .wr_evt     (wr_evt),
    .pulse_all  (pulse_all),
    .x_ptr      (ptr_w[0]),
    .y_ptr      (ptr_w[1]),
    .x_cnt_mode (x_cnt_mode_o),
    .y_idx_mode (y_idx_mode_o)
);

// File: tb/dual_axis_busregs_tb.sv
module dual_axis_busregs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic        bus_cd = 1'b0;
    logic        bus_sel_y = 1'b0;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [23:0] x_latch_i = 24'h0;
    logic [23:0] y_latch_i = 24'h0;
    logic [6:0]  x_flags_i = 7'h0;
    logic [6:0]  y_flags_i = 7'h0;
    logic [23:0] x_preset_o, y_preset_o;
    logic [4:0]  x_cnt_mode_o, y_cnt_mode_o, x_io_mode_o, y_io_mode_o;
    logic [2:0]  x_idx_mode_o, y_idx_mode_o;
    logic [1:0]  cnt_reset_o, stat_clear_o, err_clear_o;
    logic [1:0]  cnt_load_o, latch_load_o, psc_load_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [11:0] exp_q [$];
    string       tag_q [$];
    logic [11:0] pv;

    always #2 clk = ~clk;

    dual_axis_busregs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_cd(bus_cd), .bus_sel_y(bus_sel_y),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .x_latch_i(x_latch_i), .y_latch_i(y_latch_i),
        .x_flags_i(x_flags_i), .y_flags_i(y_flags_i),
        .x_preset_o(x_preset_o), .y_preset_o(y_preset_o),
        .x_cnt_mode_o(x_cnt_mode_o), .y_cnt_mode_o(y_cnt_mode_o),
        .x_io_mode_o(x_io_mode_o), .y_io_mode_o(y_io_mode_o),
        .x_idx_mode_o(x_idx_mode_o), .y_idx_mode_o(y_idx_mode_o),
        .cnt_reset_o(cnt_reset_o), .stat_clear_o(stat_clear_o),
        .err_clear_o(err_clear_o), .cnt_load_o(cnt_load_o),
        .latch_load_o(latch_load_o), .psc_load_o(psc_load_o)
    );

    assign pv = {psc_load_o, latch_load_o, cnt_load_o,
                 err_clear_o, stat_clear_o, cnt_reset_o};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Scoreboard monitor for command pulses
    always @(negedge clk) begin
        if (rst_n && pv != 12'h000) begin
            if (exp_q.size() == 0) begin
                check("R7/R8 unexpected pulse", {20'h0, pv}, 32'h0);
            end else begin
                check(tag_q.pop_front(), {20'h0, pv}, {20'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_write(input logic cd, input logic sel, input logic [7:0] d);
        bus_cd = cd; bus_sel_y = sel; bus_din = d; bus_cs_n = 1'b0;
        @(negedge clk); bus_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd_write(input logic sel, input logic [7:0] d,
                             input logic [11:0] exp_pv, input string req);
        exp_q.push_back(exp_pv);
        tag_q.push_back(req);
        bus_write(1'b1, sel, d);
    endtask

    task automatic bus_read(input logic cd, input logic sel,
                            input logic [7:0] exp, input string req);
        bus_cd = cd; bus_sel_y = sel; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check({req, " oe"}, {31'h0, bus_oe}, 32'h1);
        check(req, {24'h0, bus_dout}, {24'h0, exp});
        bus_rd_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check("watchdog", 32'h1, 32'h0);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 x preset", {8'h0, x_preset_o}, 32'h0);
        check("R1 y preset", {8'h0, y_preset_o}, 32'h0);
        check("R1 modes", {x_cnt_mode_o, y_cnt_mode_o, x_io_mode_o, y_io_mode_o,
                           x_idx_mode_o, y_idx_mode_o}, 32'h0);
        check("R1 pulses", {20'h0, pv}, 32'h0);
        check("R1 oe", {31'h0, bus_oe}, 32'h0);

        x_latch_i = 24'hA1B2C3; y_latch_i = 24'hD4E5F6;
        x_flags_i = 7'h55;      y_flags_i = 7'h2A;

        // R2: preset byte order, axis isolation
        bus_write(1'b0, 1'b0, 8'h11);
        bus_write(1'b0, 1'b0, 8'h22);
        bus_write(1'b0, 1'b0, 8'h33);
        check("R2 x preset", {8'h0, x_preset_o}, 32'h00332211);
        check("R2 y untouched", {8'h0, y_preset_o}, 32'h0);
        bus_write(1'b0, 1'b1, 8'h44);
        check("R2 y byte0", {8'h0, y_preset_o}, 32'h00000044);
        check("R2 x untouched", {8'h0, x_preset_o}, 32'h00332211);

        // R3: per-axis pointers and wrap (Y pointer now 1, X pointer 0)
        bus_read(1'b0, 1'b1, 8'hE5, "R3 y byte1");
        bus_read(1'b0, 1'b1, 8'hD4, "R3 y byte2");
        bus_read(1'b0, 1'b1, 8'hF6, "R3 y wrap byte0");
        bus_read(1'b0, 1'b0, 8'hC3, "R3 x byte0");

        // R9: flag reads, pointer kept
        bus_read(1'b1, 1'b0, 8'h55, "R9 x flags");
        bus_read(1'b1, 1'b1, 8'h2A, "R9 y flags");
        x_flags_i = 7'h7F;
        bus_read(1'b1, 1'b0, 8'h7F, "R9 flag bit7 zero");
        bus_read(1'b0, 1'b0, 8'hB2, "R9 flag read keeps pointer");

        // R6: pointer reset on one axis
        bus_write(1'b1, 1'b0, 8'h01);
        bus_read(1'b0, 1'b0, 8'hC3, "R6 x pointer reset");
        bus_read(1'b0, 1'b1, 8'hE5, "R6 y pointer untouched");

        // R5: broadcast pointer reset
        bus_write(1'b1, 1'b0, 8'h81);
        bus_read(1'b0, 1'b1, 8'hF6, "R5 broadcast pointer reset");

        // R7 / R8: command pulses through the scoreboard
        cmd_write(1'b0, 8'h02, 12'h001, "R7 x counter reset");
        cmd_write(1'b1, 8'h04, 12'h008, "R7 y status clear");
        cmd_write(1'b0, 8'h06, 12'h010, "R7 x error clear");
        cmd_write(1'b1, 8'h08, 12'h080, "R8 y preset to counter");
        cmd_write(1'b0, 8'h10, 12'h100, "R8 x counter to latch");
        cmd_write(1'b1, 8'h18, 12'h800, "R8 y prescaler load");
        cmd_write(1'b0, 8'h9A, 12'hC03, "R5 broadcast reset and prescaler");

        // R4: mode registers
        bus_write(1'b1, 1'b0, 8'h35);
        check("R4 x count mode", {27'h0, x_cnt_mode_o}, 32'h15);
        check("R4 y count mode", {27'h0, y_cnt_mode_o}, 32'h0);
        bus_write(1'b1, 1'b1, 8'h4B);
        check("R4 y io mode", {27'h0, y_io_mode_o}, 32'h0B);
        check("R4 x io mode", {27'h0, x_io_mode_o}, 32'h0);
        bus_write(1'b1, 1'b0, 8'h65);
        check("R4 x index mode", {29'h0, x_idx_mode_o}, 32'h5);
        check("R4 x count kept", {27'h0, x_cnt_mode_o}, 32'h15);

        // R5: broadcast mode writes
        bus_write(1'b1, 1'b1, 8'hAE);
        check("R5 x count bcast", {27'h0, x_cnt_mode_o}, 32'h0E);
        check("R5 y count bcast", {27'h0, y_cnt_mode_o}, 32'h0E);
        bus_write(1'b1, 1'b0, 8'hFF);
        check("R5 idx bcast", {26'h0, x_idx_mode_o, y_idx_mode_o}, 32'h3F);

        // R10: strobes with chip-select high are ignored
        bus_cd = 1'b0; bus_sel_y = 1'b0; bus_din = 8'hEE; bus_cs_n = 1'b1;
        @(negedge clk); bus_wr_n = 1'b0;
        repeat (2) @(negedge clk); bus_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 preset kept", {8'h0, x_preset_o}, 32'h00332211);
        bus_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 no oe without cs", {31'h0, bus_oe}, 32'h0);
        check("R10 dout quiet", {24'h0, bus_dout}, 32'h0);
        bus_rd_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_read(1'b0, 1'b0, 8'hC3, "R10 pointer kept");

        // R11: long strobe acts once, timed update (X pointer now 1)
        bus_write(1'b1, 1'b0, 8'h01);
        bus_cd = 1'b0; bus_sel_y = 1'b0; bus_din = 8'h99; bus_cs_n = 1'b0;
        @(negedge clk); bus_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R11 no early update", {8'h0, x_preset_o}, 32'h00332211);
        bus_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11 not before third edge", {8'h0, x_preset_o}, 32'h00332211);
        @(negedge clk);
        check("R11 update at third edge", {8'h0, x_preset_o}, 32'h00332299);
        bus_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(1'b0, 1'b0, 8'hB2, "R11 single pointer step");

        repeat (4) @(negedge clk);
        check("R7/R8 all pulses seen", exp_q.size(), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule